// File: doc/BRIEF.md
# Word-Counted I/O Channel Sequencer

This block runs transfers between one I/O device and main storage without help from the processor. The processor issues a load request that carries the storage address of a command word. The channel fetches that 36-bit command and takes three fields from it: a 3-bit operation code, a 15-bit word count and a 15-bit starting storage address. It then moves words in one of two directions, one word at a time. In the inbound direction it takes words from the device over a valid/ready handshake and writes them to storage. In the outbound direction it reads words from storage and offers them to the device. Each word moves the storage address up by one and the count down by one.

When the count runs out, the operation code decides what follows. A disconnecting command releases the channel, which goes idle. A chaining command makes the channel fetch the next command from a command location counter. That counter starts at the load address and steps by one on every command fetch.

Storage is shared with the processor. The channel never has more than one storage access in flight. It keeps its request low in every cycle in which the processor holds storage.

Top module: `chan_seq`

## Requirements
- R1: While rst_ni is low, busy_o, ld_err_o, mem_req_o, dev_in_ready_o and dev_out_valid_o are all 0.
- R2: A load request taken while idle raises busy_o in the next cycle. The first storage access after it is a read (mem_we_o=0) at ld_addr_i.
- R3: In a command word, bits [35:33] are the operation code, bits [32:18] the word count and bits [14:0] the first data address. Bits [17:15] are ignored. Opcode bit 35 set means disconnect at count end, and clear means chain. Opcode bits [34:33] give the direction: 01 is device to storage, 10 is storage to device.
- R4: For direction 01, the next count words accepted on the device input (valid and ready both high) are written to storage in order, at the start address and the addresses that follow.
- R5: For direction 10, count words are read from ascending storage addresses starting at the start address. They are offered on dev_out_data_o in that order, and each is held stable until dev_out_ready_i accepts it.
- R6: After a disconnecting command exhausts its count, busy_o falls. While idle the channel makes no storage access and no device handshake.
- R7: After a chaining command exhausts its count, the next command is read from the address after the previously fetched command.
- R8: A command with a word count of 0 moves no data and goes straight to its end-of-count action (chain or disconnect).
- R9: mem_req_o is never high while cpu_hold_i is high. A request held off in this way is issued once cpu_hold_i falls.
- R10: After a storage request has been issued, mem_req_o stays low until mem_done_i returns for it.
- R11: A load request while busy_o is high is ignored, and ld_err_o is high for exactly the following cycle.
- R12: A fetched command whose direction bits are 00 or 11 ends the operation at once. busy_o falls with no data access, whatever the values of bit 35 and the count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| ld_req_i | input | 1 | Load request from the processor |
| ld_addr_i | input | 15 | Storage address of the first command |
| busy_o | output | 1 | Channel running a command sequence |
| ld_err_o | output | 1 | One-cycle pulse: load request rejected while busy |
| cpu_hold_i | input | 1 | Processor currently owns storage |
| mem_req_o | output | 1 | Storage access request; the access is taken in the same cycle |
| mem_we_o | output | 1 | 1 = write, 0 = read |
| mem_addr_o | output | 15 | Storage address |
| mem_wdata_o | output | 36 | Storage write data |
| mem_done_i | input | 1 | Completion of the outstanding access |
| mem_rdata_i | input | 36 | Read data, valid with mem_done_i |
| dev_in_valid_i | input | 1 | Device has an inbound word |
| dev_in_data_i | input | 36 | Inbound word |
| dev_in_ready_o | output | 1 | Channel accepts an inbound word |
| dev_out_valid_o | output | 1 | Channel offers an outbound word |
| dev_out_data_o | output | 36 | Outbound word |
| dev_out_ready_i | input | 1 | Device accepts the outbound word |

## Verification
The hardest situations to reach from the ports are those where a storage access is pending at the same moment as some other event. One is the processor holding storage while a fetch is due. Another is a chain of commands whose middle member has a zero count, so two fetches follow each other with no data phase between them. The bench's storage model answers two cycles after each request and logs every access address and direction. A chained sequence is then checked against the exact expected access list. The processor hold is raised before a load, so the command fetch itself is deferred, and the storage model counts any request seen under hold or while an access is still pending.

// File: rtl/chan_seq_pkg.sv
package chan_seq_pkg;
  localparam int WORD_W  = 36;
  localparam int ADDR_W  = 15;
  localparam int CNT_W   = 15;
  localparam int OP_W    = 3;
  localparam int OP_LSB  = WORD_W - OP_W;
  localparam int CNT_LSB = OP_LSB - CNT_W;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_CMD,
    ST_IN_DEV,
    ST_IN_WR,
    ST_OUT_RD,
    ST_OUT_DEV
  } st_e;

  typedef enum logic [1:0] {
    DIR_NONE_LO = 2'b00,
    DIR_IN      = 2'b01,
    DIR_OUT     = 2'b10,
    DIR_NONE_HI = 2'b11
  } dir_e;
endpackage

// File: rtl/chan_seq_dec.sv
module chan_seq_dec
  import chan_seq_pkg::*;
(
  input  logic [OP_W-1:0]  op_i,
  input  logic [CNT_W-1:0] cnt_i,
  output logic             disc_o,
  output logic             go_in_o,
  output logic             go_out_o,
  output logic             stop_o,
  output logic             zero_o
);
  dir_e dir;

  assign dir      = dir_e'(op_i[1:0]);
  assign disc_o   = op_i[OP_W-1];
  assign go_in_o  = (dir == DIR_IN);
  assign go_out_o = (dir == DIR_OUT);
  assign stop_o   = !(go_in_o || go_out_o);
  assign zero_o   = (cnt_i == '0);
endmodule

// File: rtl/chan_seq_mem_if.sv
module chan_seq_mem_if (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic want_i,
  input  logic hold_i,
  input  logic done_i,
  output logic req_o,
  output logic done_o
);
  logic outst_q;

  // one access in flight; yield to processor ownership
  assign req_o  = want_i && !hold_i && !outst_q;
  assign done_o = done_i && outst_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     outst_q <= 1'b0;
    else if (req_o)  outst_q <= 1'b1;
    else if (done_o) outst_q <= 1'b0;
  end
endmodule

// File: rtl/chan_seq_ctrs.sv
module chan_seq_ctrs
  import chan_seq_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              clc_load_i,
  input  logic [ADDR_W-1:0] clc_val_i,
  input  logic              clc_inc_i,
  input  logic              cmd_load_i,
  input  logic [CNT_W-1:0]  cnt_val_i,
  input  logic [ADDR_W-1:0] addr_val_i,
  input  logic              step_i,
  output logic [ADDR_W-1:0] clc_o,
  output logic [CNT_W-1:0]  cnt_o,
  output logic [ADDR_W-1:0] addr_o,
  output logic              last_o
);
  logic [ADDR_W-1:0] clc_q, addr_q;
  logic [CNT_W-1:0]  cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)         clc_q <= '0;
    else if (clc_load_i) clc_q <= clc_val_i;
    else if (clc_inc_i)  clc_q <= clc_q + 1'b1;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q  <= '0;
      addr_q <= '0;
    end else if (cmd_load_i) begin
      cnt_q  <= cnt_val_i;
      addr_q <= addr_val_i;
    end else if (step_i) begin
      cnt_q  <= cnt_q - 1'b1;
      addr_q <= addr_q + 1'b1;
    end
  end

  assign clc_o  = clc_q;
  assign cnt_o  = cnt_q;
  assign addr_o = addr_q;
  assign last_o = (cnt_q == CNT_W'(1));
endmodule

// File: rtl/chan_seq.sv
module chan_seq
  import chan_seq_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              ld_req_i,
  input  logic [ADDR_W-1:0] ld_addr_i,
  output logic              busy_o,
  output logic              ld_err_o,
  input  logic              cpu_hold_i,
  output logic              mem_req_o,
  output logic              mem_we_o,
  output logic [ADDR_W-1:0] mem_addr_o,
  output logic [WORD_W-1:0] mem_wdata_o,
  input  logic              mem_done_i,
  input  logic [WORD_W-1:0] mem_rdata_i,
  input  logic              dev_in_valid_i,
  input  logic [WORD_W-1:0] dev_in_data_i,
  output logic              dev_in_ready_o,
  output logic              dev_out_valid_o,
  output logic [WORD_W-1:0] dev_out_data_o,
  input  logic              dev_out_ready_i
);
  st_e               state_q, state_d, end_st;
  logic              disc_q, disc_d;
  logic              err_q;
  logic [WORD_W-1:0] buf_q;
  logic              want, m_done;
  logic              clc_load, cmd_load, step;
  logic [ADDR_W-1:0] clc, cur_addr;
  logic [CNT_W-1:0]  cnt;
  logic              last;
  logic              dec_disc, dec_in, dec_out, dec_stop, dec_zero;

  chan_seq_dec i_dec (
    .op_i     (mem_rdata_i[WORD_W-1:OP_LSB]),
    .cnt_i    (mem_rdata_i[CNT_LSB +: CNT_W]),
    .disc_o   (dec_disc),
    .go_in_o  (dec_in),
    .go_out_o (dec_out),
    .stop_o   (dec_stop),
    .zero_o   (dec_zero)
  );

  chan_seq_ctrs i_ctrs (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .clc_load_i (clc_load),
    .clc_val_i  (ld_addr_i),
    .clc_inc_i  (cmd_load),
    .cmd_load_i (cmd_load),
    .cnt_val_i  (mem_rdata_i[CNT_LSB +: CNT_W]),
    .addr_val_i (mem_rdata_i[ADDR_W-1:0]),
    .step_i     (step),
    .clc_o      (clc),
    .cnt_o      (cnt),
    .addr_o     (cur_addr),
    .last_o     (last)
  );

  chan_seq_mem_if i_mem_if (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .want_i (want),
    .hold_i (cpu_hold_i),
    .done_i (mem_done_i),
    .req_o  (mem_req_o),
    .done_o (m_done)
  );

  assign want   = (state_q == ST_CMD) || (state_q == ST_IN_WR) || (state_q == ST_OUT_RD);
  assign end_st = disc_q ? ST_IDLE : ST_CMD;

  always_comb begin
    state_d  = state_q;
    disc_d   = disc_q;
    clc_load = 1'b0;
    cmd_load = 1'b0;
    step     = 1'b0;
    unique case (state_q)
      ST_IDLE: begin
        if (ld_req_i) begin
          clc_load = 1'b1;
          state_d  = ST_CMD;
        end
      end
      ST_CMD: begin
        if (m_done) begin
          cmd_load = 1'b1;
          disc_d   = dec_disc;
          if (dec_stop)      state_d = ST_IDLE;
          else if (dec_zero) state_d = dec_disc ? ST_IDLE : ST_CMD;
          else if (dec_in)   state_d = ST_IN_DEV;
          else if (dec_out)  state_d = ST_OUT_RD;
        end
      end
      ST_IN_DEV: begin
        if (dev_in_valid_i) state_d = ST_IN_WR;
      end
      ST_IN_WR: begin
        if (m_done) begin
          step    = 1'b1;
          state_d = last ? end_st : ST_IN_DEV;
        end
      end
      ST_OUT_RD: begin
        if (m_done) state_d = ST_OUT_DEV;
      end
      ST_OUT_DEV: begin
        if (dev_out_ready_i) begin
          step    = 1'b1;
          state_d = last ? end_st : ST_OUT_RD;
        end
      end
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      disc_q  <= 1'b0;
      err_q   <= 1'b0;
    end else begin
      state_q <= state_d;
      disc_q  <= disc_d;
      err_q   <= ld_req_i && (state_q != ST_IDLE);
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                                        buf_q <= '0;
    else if ((state_q == ST_IN_DEV) && dev_in_valid_i) buf_q <= dev_in_data_i;
    else if ((state_q == ST_OUT_RD) && m_done)         buf_q <= mem_rdata_i;
  end

  assign busy_o          = (state_q != ST_IDLE);
  assign ld_err_o        = err_q;
  assign mem_we_o        = (state_q == ST_IN_WR);
  assign mem_addr_o      = (state_q == ST_CMD) ? clc : cur_addr;
  assign mem_wdata_o     = buf_q;
  assign dev_in_ready_o  = (state_q == ST_IN_DEV);
  assign dev_out_valid_o = (state_q == ST_OUT_DEV);
  assign dev_out_data_o  = buf_q;
endmodule

// File: rtl/chan_seq_chk.sv
module chan_seq_chk
  import chan_seq_pkg::*;
(
  input logic              clk_i,
  input logic              rst_ni,
  input logic              ld_req_i,
  input logic              busy_o,
  input logic              ld_err_o,
  input logic              cpu_hold_i,
  input logic              mem_req_o,
  input logic              mem_done_i,
  input logic              dev_in_ready_o,
  input logic              dev_out_valid_o,
  input logic              dev_out_ready_i,
  input logic [WORD_W-1:0] dev_out_data_o
);
  logic pend_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)         pend_q <= 1'b0;
    else if (mem_req_o)  pend_q <= 1'b1;
    else if (mem_done_i) pend_q <= 1'b0;
  end

  AST_BUSY_ON_LOAD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ld_req_i && !busy_o) |=> busy_o); // R2

  AST_SINGLE_DIR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(dev_in_ready_o && dev_out_valid_o)); // R4

  AST_OUT_HELD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (dev_out_valid_o && !dev_out_ready_i) |=> (dev_out_valid_o && $stable(dev_out_data_o))); // R5

  AST_IDLE_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy_o |-> (!mem_req_o && !dev_in_ready_o && !dev_out_valid_o)); // R6

  AST_HOLD_YIELD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cpu_hold_i |-> !mem_req_o); // R9

  AST_ONE_PENDING: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pend_q |-> !mem_req_o); // R10

  AST_ERR_RAISE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ld_req_i && busy_o) |=> ld_err_o); // R11

  AST_ERR_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(ld_req_i && busy_o) |=> !ld_err_o); // R11
endmodule

bind chan_seq chan_seq_chk i_chk (.*);

// File: tb/test_chan_seq.sv
`timescale 1ns/1ps
module test_chan_seq;
  import chan_seq_pkg::*;

  logic clk_i = 1'b0;
  logic rst_ni = 1'b0;
  always #2 clk_i = ~clk_i;

  logic              ld_req_i = 1'b0;
  logic [ADDR_W-1:0] ld_addr_i = '0;
  logic              busy_o, ld_err_o;
  logic              cpu_hold_i = 1'b0;
  logic              mem_req_o, mem_we_o;
  logic [ADDR_W-1:0] mem_addr_o;
  logic [WORD_W-1:0] mem_wdata_o;
  logic              mem_done_i = 1'b0;
  logic [WORD_W-1:0] mem_rdata_i = '0;
  logic              dev_in_valid_i = 1'b0;
  logic [WORD_W-1:0] dev_in_data_i = '0;
  logic              dev_in_ready_o;
  logic              dev_out_valid_o;
  logic [WORD_W-1:0] dev_out_data_o;
  logic              dev_out_ready_i = 1'b0;

  chan_seq i_chan_seq (.*);

  int total = 0;
  int bad = 0;

  // storage model (two-cycle answer), access log, device models
  logic [WORD_W-1:0] mem [0:255];
  logic              bp_we = 1'b0;
  logic [7:0]        bp_addr = '0;
  logic [WORD_W-1:0] bp_data = '0;
  logic              clr = 1'b0;
  logic              slot_v = 1'b0, slot_we = 1'b0;
  logic [7:0]        slot_a = '0;
  logic [WORD_W-1:0] slot_d = '0;
  int                acc_cnt = 0, out_n = 0, in_seq = 0;
  int                viol_pend = 0, viol_hold = 0;
  logic [15:0]       acc_log [0:63];
  logic [WORD_W-1:0] out_buf [0:63];
  logic [3:0]        tick = '0;

  function automatic logic [WORD_W-1:0] dev_word(int n);
    return {20'hC3A50, 16'(n)};
  endfunction

  function automatic logic [WORD_W-1:0] out_word(int i, int k);
    return {20'h5A0F0, 16'(i * 16 + k)};
  endfunction

  function automatic logic [WORD_W-1:0] mk_cmd(logic [2:0] op, int n, int a);
    return {op, 15'(n), 3'b101, 15'(a)};  // bits [17:15] filled to show they are ignored
  endfunction

  always @(posedge clk_i) begin
    mem_done_i <= 1'b0;
    if (!rst_ni) begin
      for (int k = 0; k < 256; k++) mem[k] <= '0;
      slot_v <= 1'b0;
    end else begin
      if (bp_we) mem[bp_addr] <= bp_data;
      if (slot_v) begin
        slot_v     <= 1'b0;
        mem_done_i <= 1'b1;
        if (slot_we) mem[slot_a] <= slot_d;
        else         mem_rdata_i <= mem[slot_a];
      end
      if (mem_req_o) begin
        if (slot_v || mem_done_i) viol_pend <= viol_pend + 1;
        if (cpu_hold_i)           viol_hold <= viol_hold + 1;
        slot_v  <= 1'b1;
        slot_we <= mem_we_o;
        slot_a  <= mem_addr_o[7:0];
        slot_d  <= mem_wdata_o;
        if (acc_cnt < 64) acc_log[acc_cnt] <= {mem_we_o, mem_addr_o};
        acc_cnt <= acc_cnt + 1;
      end
      if (dev_in_valid_i && dev_in_ready_o) in_seq <= in_seq + 1;
      if (dev_out_valid_o && dev_out_ready_i) begin
        out_buf[out_n[5:0]] <= dev_out_data_o;
        out_n <= out_n + 1;
      end
      if (clr) begin
        acc_cnt <= 0;
        out_n   <= 0;
      end
    end
  end

  always @(negedge clk_i) begin
    tick            <= tick + 1'b1;
    dev_in_valid_i  <= (tick[1:0] != 2'd1);
    dev_in_data_i   <= dev_word(in_seq);
    dev_out_ready_i <= tick[0];
  end

  task automatic chk(string req, logic [63:0] act, logic [63:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%0h exp=%0h", req, act, exp);
    end
  endtask

  task automatic poke(int a, logic [WORD_W-1:0] d);
    @(negedge clk_i);
    bp_we = 1'b1; bp_addr = 8'(a); bp_data = d;
    @(negedge clk_i);
    bp_we = 1'b0;
  endtask

  task automatic do_clr();
    @(negedge clk_i); clr = 1'b1;
    @(negedge clk_i); clr = 1'b0;
  endtask

  task automatic load(int a);
    @(negedge clk_i);
    ld_req_i = 1'b1; ld_addr_i = 15'(a);
    @(negedge clk_i);
    ld_req_i = 1'b0;
  endtask

  task automatic wait_idle();
    int n = 0;
    while (busy_o && n < 3000) begin
      @(negedge clk_i);
      n++;
    end
    chk("R6 busy_o falls", 64'(busy_o), 64'd0);
  endtask

  // {opcode, count, address}
  localparam logic [18:0] VEC [4] = '{
    {3'b101, 8'd3, 8'h40},
    {3'b110, 8'd4, 8'h60},
    {3'b101, 8'd1, 8'h80},
    {3'b110, 8'd2, 8'h90}
  };

  initial begin
    int s0, snap;
    repeat (3) @(negedge clk_i);
    chk("R1 busy_o", 64'(busy_o), 64'd0);
    chk("R1 ld_err_o", 64'(ld_err_o), 64'd0);
    chk("R1 mem_req_o", 64'(mem_req_o), 64'd0);
    chk("R1 dev_in_ready_o", 64'(dev_in_ready_o), 64'd0);
    chk("R1 dev_out_valid_o", 64'(dev_out_valid_o), 64'd0);
    rst_ni = 1'b1;
    @(negedge clk_i);

    // table walk: single disconnecting commands (R3 field layout)
    for (int i = 0; i < 4; i++) begin
      logic [2:0] op;
      int n, da;
      op = VEC[i][18:16];
      n  = int'(VEC[i][15:8]);
      da = int'(VEC[i][7:0]);
      poke(16 + i, mk_cmd(op, n, da));
      if (op == 3'b110)
        for (int k = 0; k < n; k++) poke(da + k, out_word(i, k));
      do_clr();
      s0 = in_seq;
      load(16 + i);
      chk("R2 busy_o after load", 64'(busy_o), 64'd1);
      wait_idle();
      chk("R2 first access is fetch", 64'(acc_log[0]), 64'({1'b0, 15'(16 + i)}));
      chk("R6 access count", 64'(acc_cnt), 64'(n + 1));
      if (op == 3'b101) begin
        for (int k = 0; k < n; k++)
          chk("R4 stored word (R3 fields)", 64'(mem[da + k]), 64'(dev_word(s0 + k)));
      end else begin
        chk("R5 word count out", 64'(out_n), 64'(n));
        for (int k = 0; k < n; k++)
          chk("R5 output word (R3 fields)", 64'(out_buf[k]), 64'(out_word(i, k)));
      end
    end

    // idle stays quiet
    snap = acc_cnt;
    repeat (12) @(negedge clk_i);
    chk("R6 no access while idle", 64'(acc_cnt), 64'(snap));

    // chain: in(2) -> zero-count out -> out(2) disconnect
    poke(8'h20, mk_cmd(3'b001, 2, 8'hA0));
    poke(8'h21, mk_cmd(3'b010, 0, 8'h00));
    poke(8'h22, mk_cmd(3'b110, 2, 8'h60));
    do_clr();
    s0 = in_seq;
    load(8'h20);
    wait_idle();
    chk("R7 chain access count", 64'(acc_cnt), 64'd7);
    begin
      logic [15:0] exp_log [7];
      exp_log = '{16'h0020, 16'h80A0, 16'h80A1, 16'h0021, 16'h0022, 16'h0060, 16'h0061};
      for (int k = 0; k < 7; k++)
        chk("R7 R8 access sequence", 64'(acc_log[k]), 64'(exp_log[k]));
    end
    chk("R4 chained stored word", 64'(mem[8'hA1]), 64'(dev_word(s0 + 1)));
    chk("R8 zero-count moved nothing", 64'(out_n), 64'd2);
    chk("R5 chained output word", 64'(out_buf[1]), 64'(out_word(1, 1)));

    // processor hold defers the fetch
    cpu_hold_i = 1'b1;
    do_clr();
    load(16);
    repeat (20) @(negedge clk_i);
    chk("R9 no access under hold", 64'(acc_cnt), 64'd0);
    chk("R9 still busy under hold", 64'(busy_o), 64'd1);
    cpu_hold_i = 1'b0;
    wait_idle();
    chk("R9 resumes after hold", 64'(acc_cnt), 64'd4);
    chk("R9 no request seen under hold", 64'(viol_hold), 64'd0);

    // second load while busy
    poke(8'h30, mk_cmd(3'b101, 2, 8'hB0));
    poke(8'h31, mk_cmd(3'b101, 2, 8'hC0));
    do_clr();
    load(8'h30);
    ld_req_i = 1'b1; ld_addr_i = 15'h31;
    @(negedge clk_i);
    ld_req_i = 1'b0;
    chk("R11 error pulse", 64'(ld_err_o), 64'd1);
    @(negedge clk_i);
    chk("R11 error pulse one cycle", 64'(ld_err_o), 64'd0);
    wait_idle();
    chk("R11 first sequence only", 64'(acc_cnt), 64'd3);
    chk("R11 ignored target untouched", 64'(mem[8'hC0]), 64'd0);

    // invalid direction codes
    poke(8'h38, mk_cmd(3'b000, 5, 8'hD0));
    poke(8'h39, mk_cmd(3'b111, 5, 8'hD0));
    for (int j = 0; j < 2; j++) begin
      do_clr();
      load(8'h38 + j);
      wait_idle();
      chk("R12 only the fetch", 64'(acc_cnt), 64'd1);
      chk("R12 no device output", 64'(out_n), 64'd0);
      chk("R12 no store", 64'(mem[8'hD0]), 64'd0);
    end

    chk("R10 one access pending", 64'(viol_pend), 64'd0);

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk_i);
    total++;
    bad++;
    $display("FAIL watchdog act=running exp=finished");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule